// File: doc/BRIEF.md
# Cluster Width Filter

This block takes one sensor layer's comparator hits for a single bunch crossing and keeps only the narrow clusters. Such clusters are the ones worth passing on to a stub-finding (correlation) stage. A per-channel suppression mask removes noisy channels from this trigger path; the readout path that carries the same hits elsewhere is not affected. After masking, the block finds every maximal run of adjacent hit strips. It drops any run wider than a programmable limit of one to three strips. For each run it keeps, it reports the centre at half-strip resolution.

A chip sees only its own channel range, so hits from the neighbouring chips are fed in at both edges. The single lower-side bit tells the block that a run starting at its channel 0 really began on the chip below. That chip reports such a run, so this block does not. The upper-side bits let a run that starts here and continues onto the chip above be measured at its true width. The result for each crossing has two forms. The first is a bitmap indexed by half-strip address. The second is a short list of the lowest accepted addresses, in ascending order, for a consumer that wants encoded positions. Both are registered once, so the result appears one clock after the hits.

Top module: `clus_width_filter`

## Requirements
- R1: While `rst_ni` is low, `centre_map_o`, `slot_vld_o` and `slot_addr_o` are all zero.
- R2: A single unmasked hit on channel s, with both neighbours not hit and `max_width_i` of 1 or more, gives centre address 2s. Bit i of `centre_map_o` stands for half-strip address i.
- R3: A run of two hit strips on s and s+1 gives the midpoint address 2s+1. A run of three strips from s gives 2s+2, which is its middle strip. In general the address is first index plus last index.
- R4: A run is accepted only when its width is at most `max_width_i`. A run of four or more is never accepted, and `max_width_i` = 0 accepts nothing.
- R5: A channel with `mask_i` bit set to 1 acts as not hit. It ends or splits runs, and a masked lone hit yields no cluster.
- R6: When `nbr_lo_i` is 1 and channel 0 is an unmasked hit, the run that starts at channel 0 is not reported. When `nbr_lo_i` is 1 and channel 0 is not hit, nothing is reported for that edge.
- R7: `nbr_hi_i` bit j stands for strip 127+j on the chip above. A run starting on this chip counts those strips in its width and in its address (up to 254), and it stops at the first neighbour bit that is 0.
- R8: Slot k of `slot_addr_o` is bits [8k+7:8k]. The valid slots form a prefix starting at slot 0. They hold the lowest accepted addresses in ascending order, at most four of them. Accepted clusters beyond four appear only in `centre_map_o`.
- R9: Outputs reflect the inputs present at the previous rising clock edge. Changing the inputs does not alter the outputs until the next edge.
- R10: Every address in a valid slot has its bit set in `centre_map_o`, and the map has no bit set for a run that was rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | crossing clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| max_width_i | input | 2 | widest run accepted, 0 to 3 |
| hit_i | input | 127 | comparator hit per channel |
| mask_i | input | 127 | 1 removes the channel from the trigger path |
| nbr_lo_i | input | 1 | hit on the strip just below channel 0 (lower chip) |
| nbr_hi_i | input | 3 | hits on the three strips above channel 126 (upper chip) |
| centre_map_o | output | 255 | one bit per accepted half-strip centre |
| slot_vld_o | output | 4 | valid flag per list slot |
| slot_addr_o | output | 32 | four 8-bit centre addresses, lowest first |

## Verification
Single hits at channel 0, mid-range and channel 126 confirm the even-address encoding at both edges. Pairs and triples separate the midpoint rule from the middle-strip rule. Runs of three and four are applied under every width limit, including zero, to find exactly where rejection begins. Masked channels placed inside a run show splitting apart from mere shortening. Edge patterns set the neighbour bits with and without a matching hit on channel 0 or channel 126, and with a gap among the upper neighbour bits, which separates boundary ownership from width counting. Dense patterns with more than four clusters, together with a long run of random sparse patterns, test the ordering of the list and its agreement with the map.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    // default geometry of one layer on one chip
    localparam int unsigned CH_COUNT   = 127;
    localparam int unsigned WIDTH_CAP  = 3;
    localparam int unsigned SLOT_COUNT = 4;

    // highest half-strip address is 2*(CH-1)+(CAP-1); map holds 0..that
    function automatic int unsigned map_bits(int unsigned ch, int unsigned cap);
        return 2 * ch + cap - 2;
    endfunction
endpackage

// File: rtl/cwf_edge_ext.sv
// Builds the extended, masked strip vector: index 0 is the lower neighbour,
// index s+1 is own channel s, index CH+1+j is upper neighbour j.
module cwf_edge_ext #(
    parameter int unsigned CH  = cwf_pkg::CH_COUNT,
    parameter int unsigned CAP = cwf_pkg::WIDTH_CAP,
    localparam int unsigned EXT = CH + CAP + 1
) (
    input  logic [CH-1:0]  hit_i,
    input  logic [CH-1:0]  mask_i,
    input  logic           nbr_lo_i,
    input  logic [CAP-1:0] nbr_hi_i,
    output logic [EXT-1:0] ext_o
);
    assign ext_o[0] = nbr_lo_i;

    for (genvar s = 0; s < CH; s++) begin : g_own
        assign ext_o[s+1] = hit_i[s] & ~mask_i[s];
    end

    for (genvar j = 0; j < CAP; j++) begin : g_up
        assign ext_o[CH+1+j] = nbr_hi_i[j];
    end
endmodule

// File: rtl/cwf_run_judge.sv
// For every own start strip and every width up to CAP, decides whether a
// run of exactly that width begins there and is narrow enough to keep.
module cwf_run_judge #(
    parameter int unsigned CH  = cwf_pkg::CH_COUNT,
    parameter int unsigned CAP = cwf_pkg::WIDTH_CAP,
    localparam int unsigned EXT   = CH + CAP + 1,
    localparam int unsigned MAP_W = cwf_pkg::map_bits(CH, CAP),
    localparam int unsigned MW_W  = $clog2(CAP + 1)
) (
    input  logic [EXT-1:0]   ext_i,
    input  logic [MW_W-1:0]  max_width_i,
    output logic [MAP_W-1:0] map_o
);
    logic [CAP-1:0] keep [CH];

    for (genvar s = 0; s < CH; s++) begin : g_start
        for (genvar w = 1; w <= CAP; w++) begin : g_width
            // strip before is empty, w strips set, strip after is empty
            assign keep[s][w-1] = ~ext_i[s]
                                & (&ext_i[s+w:s+1])
                                & ~ext_i[s+w+1]
                                & (max_width_i >= MW_W'(w));
        end
    end

    always_comb begin
        map_o = '0;
        for (int s = 0; s < int'(CH); s++) begin
            for (int w = 1; w <= int'(CAP); w++) begin
                map_o[2*s+w-1] = map_o[2*s+w-1] | keep[s][w-1];
            end
        end
    end
endmodule

// File: rtl/cwf_slot_pick.sv
// Takes the lowest SLOTS set bits of the centre map, in ascending order.
module cwf_slot_pick #(
    parameter int unsigned MAP_W = 255,
    parameter int unsigned SLOTS = cwf_pkg::SLOT_COUNT,
    localparam int unsigned AW = $clog2(MAP_W),
    localparam int unsigned CW = $clog2(SLOTS + 1),
    localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [MAP_W-1:0]    map_i,
    output logic [SLOTS-1:0]    vld_o,
    output logic [SLOTS*AW-1:0] addr_o
);
    logic [AW-1:0] slot [SLOTS];
    logic [CW-1:0] cnt;

    always_comb begin
        cnt   = '0;
        vld_o = '0;
        for (int k = 0; k < int'(SLOTS); k++) slot[k] = '0;
        for (int a = 0; a < int'(MAP_W); a++) begin
            if (map_i[a] && (cnt < CW'(SLOTS))) begin
                slot[cnt[IW-1:0]]  = AW'(a);
                vld_o[cnt[IW-1:0]] = 1'b1;
                cnt                = cnt + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_pack
        assign addr_o[k*AW +: AW] = slot[k];
    end
endmodule

// File: rtl/clus_width_filter.sv
module clus_width_filter #(
    parameter int unsigned CH    = cwf_pkg::CH_COUNT,
    parameter int unsigned CAP   = cwf_pkg::WIDTH_CAP,
    parameter int unsigned SLOTS = cwf_pkg::SLOT_COUNT,
    localparam int unsigned MAP_W = cwf_pkg::map_bits(CH, CAP),
    localparam int unsigned AW    = $clog2(MAP_W),
    localparam int unsigned MW_W  = $clog2(CAP + 1),
    localparam int unsigned EXT   = CH + CAP + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [MW_W-1:0]     max_width_i,
    input  logic [CH-1:0]       hit_i,
    input  logic [CH-1:0]       mask_i,
    input  logic                nbr_lo_i,
    input  logic [CAP-1:0]      nbr_hi_i,
    output logic [MAP_W-1:0]    centre_map_o,
    output logic [SLOTS-1:0]    slot_vld_o,
    output logic [SLOTS*AW-1:0] slot_addr_o
);
    typedef struct packed {
        logic [MAP_W-1:0]    map;
        logic [SLOTS-1:0]    vld;
        logic [SLOTS*AW-1:0] addr;
    } cwf_state_t;

    cwf_state_t st_d, st_q;

    logic [EXT-1:0]      ext_w;
    logic [MAP_W-1:0]    map_w;
    logic [SLOTS-1:0]    vld_w;
    logic [SLOTS*AW-1:0] addr_w;

    cwf_edge_ext #(.CH(CH), .CAP(CAP)) u_ext (
        .hit_i    (hit_i),
        .mask_i   (mask_i),
        .nbr_lo_i (nbr_lo_i),
        .nbr_hi_i (nbr_hi_i),
        .ext_o    (ext_w)
    );

    cwf_run_judge #(.CH(CH), .CAP(CAP)) u_judge (
        .ext_i       (ext_w),
        .max_width_i (max_width_i),
        .map_o       (map_w)
    );

    cwf_slot_pick #(.MAP_W(MAP_W), .SLOTS(SLOTS)) u_pick (
        .map_i  (map_w),
        .vld_o  (vld_w),
        .addr_o (addr_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.map  = map_w;
        st_d.vld  = vld_w;
        st_d.addr = addr_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign centre_map_o = st_q.map;
    assign slot_vld_o   = st_q.vld;
    assign slot_addr_o  = st_q.addr;
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker #(
    parameter int unsigned CH    = cwf_pkg::CH_COUNT,
    parameter int unsigned CAP   = cwf_pkg::WIDTH_CAP,
    parameter int unsigned SLOTS = cwf_pkg::SLOT_COUNT,
    localparam int unsigned MAP_W = cwf_pkg::map_bits(CH, CAP),
    localparam int unsigned AW    = $clog2(MAP_W),
    localparam int unsigned MW_W  = $clog2(CAP + 1)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [MW_W-1:0]     max_width_i,
    input logic [CH-1:0]       hit_i,
    input logic [CH-1:0]       mask_i,
    input logic                nbr_lo_i,
    input logic [CAP-1:0]      nbr_hi_i,
    input logic [MAP_W-1:0]    centre_map_o,
    input logic [SLOTS-1:0]    slot_vld_o,
    input logic [SLOTS*AW-1:0] slot_addr_o
);
    // set once an edge has been taken out of reset
    logic ran_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ran_q <= 1'b0;
        else         ran_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (centre_map_o == '0 && slot_vld_o == '0 && slot_addr_o == '0));

    p_zero_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (max_width_i == '0) |=> (centre_map_o == '0));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ran_q && $stable(hit_i) && $stable(mask_i) && $stable(nbr_lo_i)
         && $stable(nbr_hi_i) && $stable(max_width_i))
        |=> $stable(centre_map_o));

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        p_slot_in_map_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            slot_vld_o[k] |-> centre_map_o[slot_addr_o[k*AW +: AW]]);
        if (k > 0) begin : g_order
            p_slot_prefix_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                slot_vld_o[k] |-> slot_vld_o[k-1]);
            p_slot_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                slot_vld_o[k] |-> (slot_addr_o[k*AW +: AW] > slot_addr_o[(k-1)*AW +: AW]));
        end
    end
endmodule

bind clus_width_filter cwf_checker #(.CH(CH), .CAP(CAP), .SLOTS(SLOTS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .max_width_i  (max_width_i),
    .hit_i        (hit_i),
    .mask_i       (mask_i),
    .nbr_lo_i     (nbr_lo_i),
    .nbr_hi_i     (nbr_hi_i),
    .centre_map_o (centre_map_o),
    .slot_vld_o   (slot_vld_o),
    .slot_addr_o  (slot_addr_o)
);

// File: tb/clus_width_filter_bench.sv
module clus_width_filter_bench;
    localparam int unsigned CH    = cwf_pkg::CH_COUNT;
    localparam int unsigned CAP   = cwf_pkg::WIDTH_CAP;
    localparam int unsigned SLOTS = cwf_pkg::SLOT_COUNT;
    localparam int unsigned MAP_W = cwf_pkg::map_bits(CH, CAP);
    localparam int unsigned AW    = $clog2(MAP_W);
    localparam int unsigned MW_W  = $clog2(CAP + 1);
    localparam time         CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [MW_W-1:0]     mw = '0;
    logic [CH-1:0]       hit = '0;
    logic [CH-1:0]       msk = '0;
    logic                nlo = 1'b0;
    logic [CAP-1:0]      nhi = '0;
    logic [MAP_W-1:0]    map;
    logic [SLOTS-1:0]    vld;
    logic [SLOTS*AW-1:0] addr;

    logic [MAP_W-1:0]    exp_map = '0;
    logic [SLOTS-1:0]    exp_vld = '0;
    logic [SLOTS*AW-1:0] exp_addr = '0;
    string               exp_tag = "R1";

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clus_width_filter u_clus_width_filter (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .max_width_i  (mw),
        .hit_i        (hit),
        .mask_i       (msk),
        .nbr_lo_i     (nlo),
        .nbr_hi_i     (nhi),
        .centre_map_o (map),
        .slot_vld_o   (vld),
        .slot_addr_o  (addr)
    );

    // strip occupancy as seen by the requirements, position -1 .. CH+CAP-1
    function automatic bit occ(int i);
        if (i == -1) return nlo;
        if (i < 0) return 0;
        if (i < int'(CH)) return hit[i] && !msk[i];
        if (i < int'(CH + CAP)) return nhi[i - CH];
        return 0;
    endfunction

    // behavioural reference: scan runs, keep narrow ones, list lowest first
    task automatic model();
        int q[$];
        int i = 0;
        while (i < int'(CH)) begin
            if (occ(i) && !occ(i - 1)) begin
                int len = 0;
                while (occ(i + len)) len++;
                if (len <= int'(mw)) q.push_back(2 * i + len - 1);
                i += len;
            end else begin
                i++;
            end
        end
        exp_map  = '0;
        exp_vld  = '0;
        exp_addr = '0;
        foreach (q[n]) begin
            exp_map[q[n]] = 1'b1;
            if (n < int'(SLOTS)) begin
                exp_vld[n] = 1'b1;
                exp_addr[n*AW +: AW] = AW'(q[n]);
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (map !== exp_map || vld !== exp_vld || addr !== exp_addr) begin
            fails++;
            $display("FAIL %s: got map=%h vld=%b addr=%h, expected map=%h vld=%b addr=%h",
                     tag, map, vld, addr, exp_map, exp_vld, exp_addr);
        end
    endtask

    // check result of previous vector, then apply the next one
    task automatic drive(logic [CH-1:0] h, logic [CH-1:0] m, logic lo,
                         logic [CAP-1:0] hi, logic [MW_W-1:0] w, string tag);
        @(negedge clk);
        compare(exp_tag);
        hit = h; msk = m; nlo = lo; nhi = hi; mw = w;
        #1;
        // R9: outputs must not move before the next rising edge
        compare("R9");
        model();
        exp_tag = tag;
    endtask

    function automatic logic [CH-1:0] bits(int a, int b = -1, int c = -1, int d = -1);
        logic [CH-1:0] v = '0;
        v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        if (d >= 0) v[d] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no finish, expected finish before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CH-1:0] z = '0;
        logic [CH-1:0] dense;
        // R1: reset state
        hit = '1; mw = 2'd3;
        repeat (2) @(negedge clk);
        compare("R1");
        hit = '0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        model();
        exp_tag = "R1";

        // R2: single hits, low edge, middle, high edge
        drive(bits(0),   z, 0, '0, 2'd1, "R2");
        drive(bits(50),  z, 0, '0, 2'd1, "R2");
        drive(bits(126), z, 0, '0, 2'd3, "R2");
        // R3: pairs and triples
        drive(bits(10, 11),     z, 0, '0, 2'd2, "R3");
        drive(bits(10, 11, 12), z, 0, '0, 2'd3, "R3");
        drive(bits(70, 71, 90), z, 0, '0, 2'd3, "R3");
        // R4: width limit
        drive(bits(10, 11, 12),     z, 0, '0, 2'd2, "R4");
        drive(bits(10, 11),         z, 0, '0, 2'd1, "R4");
        drive(bits(40, 41, 42, 43), z, 0, '0, 2'd3, "R4");
        drive(bits(5),              z, 0, '0, 2'd0, "R4");
        drive(bits(5, 60, 61),      z, 0, '0, 2'd2, "R4");
        // R5: masking
        drive(bits(20, 21, 22), bits(21), 0, '0, 2'd3, "R5");
        drive(bits(30),         bits(30), 0, '0, 2'd3, "R5");
        drive(bits(40, 41, 42, 43), bits(43), 0, '0, 2'd3, "R5");
        drive(bits(40, 41, 42, 43), bits(40), 0, '0, 2'd2, "R5");
        // R6: lower neighbour owns runs crossing channel 0
        drive(bits(0),    z, 1, '0, 2'd3, "R6");
        drive(bits(0, 1), z, 1, '0, 2'd3, "R6");
        drive(bits(1),    z, 1, '0, 2'd3, "R6");
        drive(bits(0),    bits(0), 1, '0, 2'd3, "R6");
        // R7: upper neighbour extends runs
        drive(bits(126), z, 0, 3'b001, 2'd3, "R7");
        drive(bits(126), z, 0, 3'b011, 2'd3, "R7");
        drive(bits(126), z, 0, 3'b111, 2'd3, "R7");
        drive(bits(126), z, 0, 3'b010, 2'd3, "R7");
        drive(bits(125, 126), z, 0, 3'b001, 2'd3, "R7");
        drive(bits(126), z, 0, 3'b001, 2'd1, "R7");
        drive(z,         z, 0, 3'b111, 2'd3, "R7");
        // R8: more clusters than slots
        dense = '0;
        for (int s = 3; s < 120; s += 9) dense[s] = 1'b1;
        dense[30] = 1'b1; dense[31] = 1'b1;
        drive(dense, z, 0, '0, 2'd3, "R8");
        drive(bits(100, 7, 60, 33), z, 0, '0, 2'd1, "R8");
        // R10: random sparse patterns
        for (int v = 0; v < 400; v++) begin
            logic [CH-1:0] rh = '0;
            logic [CH-1:0] rm = '0;
            for (int s = 0; s < int'(CH); s++) begin
                rh[s] = ($urandom_range(0, 5) == 0) || (s > 0 && rh[s-1] && $urandom_range(0, 2) != 0);
                rm[s] = ($urandom_range(0, 15) == 0);
            end
            drive(rh, rm, 1'($urandom_range(0, 1)), CAP'($urandom_range(0, 7)),
                  MW_W'($urandom_range(0, 3)), "R10");
        end
        drive(z, z, 0, '0, 2'd3, "R10");
        @(negedge clk);
        compare(exp_tag);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule